// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the processor side of an AT-style keyboard controller. The host reaches it through two byte addresses. The data address (`host_addr` = 0) reads the output buffer and writes data bytes. The status/command address (`host_addr` = 1) reads the status byte and writes controller commands. Every accepted write sits in a one-byte input register for exactly one cycle. In the next cycle the command sequencer consumes that byte.

A command can do one of three things: load a reply into the output buffer, change a bit of the internal configuration byte, or arm an argument slot. When an argument slot is armed, the next data write is taken as that command's argument. When no argument is waiting, a data write is forwarded to the keyboard as a one-cycle pulse on the device byte interface. A device can also push bytes into the output buffer, but only while the buffer is empty and the input register is idle. The interrupt output follows the output-full flag, gated by configuration bit 0.

Top module: `kbc_host_if`

## Requirements
- R1: `host_rdata` at address 1 is the status byte. Bit 0 is output-full, bit 1 is input-full, bit 2 is configuration bit 2, bit 3 is last-write-was-command, bit 4 is `kbd_switch_on`, and bits 7..5 are `dev_err[2:0]`. After reset the configuration byte is 00h and all flags are 0.
- R2: A write that is accepted while input-full is 0 does three things. It sets input-full for exactly one cycle. It sets status bit 3 when `host_addr`=1 and clears it when `host_addr`=0. A write made while input-full is 1 is dropped.
- R3: A data write with no pending argument drives `kbd_tx_valid` high for one cycle, with the byte on `tx_byte`, two clock edges after the write. `kbd_tx_valid` and `aux_tx_valid` are never high together.
- R4: Command 20h loads the configuration byte into the output buffer. After command 60h, the next data byte becomes the configuration byte, with bit 7 forced to 0.
- R5: Command ADh sets configuration bit 4 and AEh clears it. Command A7h sets configuration bit 5 and A8h clears it.
- R6: Command AAh returns 55h. Command ABh returns `kbd_line_code` zero-extended. Command A9h returns `aux_line_code` zero-extended. Code 0 means no fault.
- R7: After command D2h, the next data byte is loaded into the output buffer and is not forwarded. After command D4h, the next data byte is sent with `aux_tx_valid`.
- R8: Command A4h returns FAh when a password is installed and F1h when none is. Command A5h absorbs data bytes, without forwarding them, until a 00h byte arrives. The password counts as installed only if at least one nonzero byte came before that 00h.
- R9: `host_rdata` at address 0 is the output buffer. A read at address 0 clears output-full. A reply loaded while output-full is set overwrites the old byte.
- R10: `irq` is high exactly while output-full is 1 and configuration bit 0 is 1.
- R11: `dev_rx_ready` is 1 only when output-full and input-full are both 0. A device byte that is offered while ready is loaded into the output buffer. A byte that is offered while not ready leaves the output buffer unchanged.
- R12: A command code not listed in R4 to R8 changes nothing except status bit 3, and any pending argument stays armed. A listed command cancels any pending argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = data, 1 = status/command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Output buffer or status byte |
| irq | output | 1 | Output-full interrupt |
| kbd_switch_on | input | 1 | Keyboard enable switch, shown in status bit 4 |
| dev_err | input | 3 | Transmit timeout, receive timeout, parity error |
| kbd_line_code | input | CODE_W | Keyboard line test result |
| aux_line_code | input | CODE_W | Auxiliary line test result |
| dev_rx_valid | input | 1 | Device offers a byte |
| dev_rx_byte | input | 8 | Device byte |
| dev_rx_ready | output | 1 | Output buffer can take a device byte |
| kbd_tx_valid | output | 1 | Byte for the keyboard |
| aux_tx_valid | output | 1 | Byte for the auxiliary device |
| tx_byte | output | 8 | Forwarded byte |
| cfg_byte | output | 8 | Configuration byte for device-side logic |

## Verification
The assertions watch properties that must hold on every cycle:
- input-full lasts exactly one cycle;
- the two forward strobes are exclusive, and a keyboard strobe only follows a data byte;
- configuration bit 7 stays 0;
- output-full only rises from a reply or an accepted device byte, and a full buffer keeps its byte while idle;
- an unknown command leaves the configuration untouched.

Several behaviours need a full scenario to show them and are covered by the bench:
- the reply values and the argument routing;
- the password collection ending on 00h;
- a pending argument surviving an unknown code;
- a write being dropped during input-full;
- the interrupt gating across random configuration bytes.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ARG_NONE,
        ARG_CFG,
        ARG_OBUF,
        ARG_AUX,
        ARG_PASS
    } arg_kind_e;

    typedef struct packed {
        logic  valid;
        logic  is_cmd;
        byte_t data;
    } host_byte_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } byte_evt_t;

    localparam byte_t OP_RD_CFG    = 8'h20;
    localparam byte_t OP_WR_CFG    = 8'h60;
    localparam byte_t OP_PW_TEST   = 8'hA4;
    localparam byte_t OP_PW_LOAD   = 8'hA5;
    localparam byte_t OP_AUX_OFF   = 8'hA7;
    localparam byte_t OP_AUX_ON    = 8'hA8;
    localparam byte_t OP_AUX_TEST  = 8'hA9;
    localparam byte_t OP_SELF_TEST = 8'hAA;
    localparam byte_t OP_KBD_TEST  = 8'hAB;
    localparam byte_t OP_KBD_OFF   = 8'hAD;
    localparam byte_t OP_KBD_ON    = 8'hAE;
    localparam byte_t OP_WR_OBUF   = 8'hD2;
    localparam byte_t OP_WR_AUX    = 8'hD4;

    localparam byte_t RSP_SELF_OK = 8'h55;
    localparam byte_t RSP_PW_YES  = 8'hFA;
    localparam byte_t RSP_PW_NO   = 8'hF1;

    localparam int CFG_IRQ_EN  = 0;
    localparam int CFG_SYS     = 2;
    localparam int CFG_KBD_OFF = 4;
    localparam int CFG_AUX_OFF = 5;
    localparam int CFG_RSVD    = 7;

    function automatic logic is_known_cmd(input byte_t op);
        case (op)
            OP_RD_CFG, OP_WR_CFG, OP_PW_TEST, OP_PW_LOAD, OP_AUX_OFF,
            OP_AUX_ON, OP_AUX_TEST, OP_SELF_TEST, OP_KBD_TEST, OP_KBD_OFF,
            OP_KBD_ON, OP_WR_OBUF, OP_WR_AUX: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic byte_t pack_status(input logic obf, input logic ibf,
                                          input logic sys, input logic cmd,
                                          input logic kbd, input logic [2:0] err);
        return {err, kbd, cmd, sys, ibf, obf};
    endfunction

endpackage

// File: rtl/kbc_in_latch.sv
module kbc_in_latch
    import kbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       addr,
    input  byte_t      wdata,
    output host_byte_t ib,
    output logic       cmd_flag
);

    host_byte_t ib_q;
    logic       cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ib_q  <= '0;
            cmd_q <= 1'b0;
        end else if (wr && !ib_q.valid) begin
            ib_q.valid  <= 1'b1;
            ib_q.is_cmd <= addr;
            ib_q.data   <= wdata;
            cmd_q       <= addr;
        end else begin
            ib_q.valid <= 1'b0;
        end
    end

    assign ib       = ib_q;
    assign cmd_flag = cmd_q;

    AST_IBF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ib_q.valid |=> !ib_q.valid); // R2

endmodule

// File: rtl/kbc_cmd_seq.sv
module kbc_cmd_seq
    import kbc_pkg::*;
#(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  host_byte_t        ib,
    input  logic [CODE_W-1:0] kbd_code,
    input  logic [CODE_W-1:0] aux_code,
    output byte_t             cfg,
    output byte_evt_t         reply,
    output byte_evt_t         kbd_tx,
    output byte_evt_t         aux_tx
);

    localparam int unsigned PAD_W = BYTE_W - CODE_W;

    byte_t     cfg_q, cfg_n;
    arg_kind_e arg_q, arg_n;
    logic      pw_inst_q, pw_inst_n;
    logic      pw_seen_q, pw_seen_n;
    byte_evt_t kbd_q, kbd_n, aux_q, aux_n;
    byte_evt_t reply_n;

    always_comb begin
        cfg_n     = cfg_q;
        arg_n     = arg_q;
        pw_inst_n = pw_inst_q;
        pw_seen_n = pw_seen_q;
        kbd_n     = '0;
        aux_n     = '0;
        reply_n   = '0;
        if (ib.valid && ib.is_cmd) begin
            if (is_known_cmd(ib.data)) begin
                arg_n = ARG_NONE;
            end
            case (ib.data)
                OP_RD_CFG: begin
                    reply_n.valid = 1'b1;
                    reply_n.data  = cfg_q;
                end
                OP_WR_CFG:  arg_n = ARG_CFG;
                OP_WR_OBUF: arg_n = ARG_OBUF;
                OP_WR_AUX:  arg_n = ARG_AUX;
                OP_PW_LOAD: begin
                    arg_n     = ARG_PASS;
                    pw_seen_n = 1'b0;
                end
                OP_PW_TEST: begin
                    reply_n.valid = 1'b1;
                    reply_n.data  = pw_inst_q ? RSP_PW_YES : RSP_PW_NO;
                end
                OP_SELF_TEST: begin
                    reply_n.valid = 1'b1;
                    reply_n.data  = RSP_SELF_OK;
                end
                OP_KBD_TEST: begin
                    reply_n.valid = 1'b1;
                    reply_n.data  = {{PAD_W{1'b0}}, kbd_code};
                end
                OP_AUX_TEST: begin
                    reply_n.valid = 1'b1;
                    reply_n.data  = {{PAD_W{1'b0}}, aux_code};
                end
                OP_KBD_OFF: cfg_n[CFG_KBD_OFF] = 1'b1;
                OP_KBD_ON:  cfg_n[CFG_KBD_OFF] = 1'b0;
                OP_AUX_OFF: cfg_n[CFG_AUX_OFF] = 1'b1;
                OP_AUX_ON:  cfg_n[CFG_AUX_OFF] = 1'b0;
                default: ;
            endcase
        end else if (ib.valid) begin
            case (arg_q)
                ARG_CFG: begin
                    cfg_n           = ib.data;
                    cfg_n[CFG_RSVD] = 1'b0;
                    arg_n           = ARG_NONE;
                end
                ARG_OBUF: begin
                    reply_n.valid = 1'b1;
                    reply_n.data  = ib.data;
                    arg_n         = ARG_NONE;
                end
                ARG_AUX: begin
                    aux_n.valid = 1'b1;
                    aux_n.data  = ib.data;
                    arg_n       = ARG_NONE;
                end
                ARG_PASS: begin
                    if (ib.data == '0) begin
                        pw_inst_n = pw_seen_q;
                        pw_seen_n = 1'b0;
                        arg_n     = ARG_NONE;
                    end else begin
                        pw_seen_n = 1'b1;
                    end
                end
                default: begin
                    kbd_n.valid = 1'b1;
                    kbd_n.data  = ib.data;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            arg_q     <= ARG_NONE;
            pw_inst_q <= 1'b0;
            pw_seen_q <= 1'b0;
            kbd_q     <= '0;
            aux_q     <= '0;
        end else begin
            cfg_q     <= cfg_n;
            arg_q     <= arg_n;
            pw_inst_q <= pw_inst_n;
            pw_seen_q <= pw_seen_n;
            kbd_q     <= kbd_n;
            aux_q     <= aux_n;
        end
    end

    assign cfg    = cfg_q;
    assign reply  = reply_n;
    assign kbd_tx = kbd_q;
    assign aux_tx = aux_q;

    AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_q[CFG_RSVD]); // R4
    AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(kbd_q.valid && aux_q.valid)); // R3
    AST_KBD_TX_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        kbd_q.valid |-> $past(ib.valid && !ib.is_cmd)); // R3
    AST_UNKNOWN_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        (ib.valid && ib.is_cmd && !is_known_cmd(ib.data)) |=> $stable(cfg_q)); // R12

endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
    import kbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  byte_evt_t reply,
    input  logic      rx_valid,
    input  byte_t     rx_data,
    input  logic      ibf,
    input  logic      rd_clear,
    output logic      obf,
    output byte_t     obuf,
    output logic      rx_ready
);

    logic  obf_q;
    byte_t obuf_q;
    logic  rx_take;

    assign rx_ready = !obf_q && !ibf;
    assign rx_take  = rx_valid && rx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            obf_q  <= 1'b0;
            obuf_q <= '0;
        end else if (reply.valid) begin
            obf_q  <= 1'b1;
            obuf_q <= reply.data;
        end else if (rx_take) begin
            obf_q  <= 1'b1;
            obuf_q <= rx_data;
        end else if (rd_clear) begin
            obf_q <= 1'b0;
        end
    end

    assign obf  = obf_q;
    assign obuf = obuf_q;

    AST_OBF_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(obf_q) |-> $past(reply.valid || (rx_valid && !obf_q && !ibf))); // R11
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (obf_q && !ibf) |=> $stable(obuf_q)); // R11
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && !reply.valid && obf_q) |=> !obf_q); // R9

endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq,
    input  logic              kbd_switch_on,
    input  logic [2:0]        dev_err,
    input  logic [CODE_W-1:0] kbd_line_code,
    input  logic [CODE_W-1:0] aux_line_code,
    input  logic              dev_rx_valid,
    input  logic [7:0]        dev_rx_byte,
    output logic              dev_rx_ready,
    output logic              kbd_tx_valid,
    output logic              aux_tx_valid,
    output logic [7:0]        tx_byte,
    output logic [7:0]        cfg_byte
);

    host_byte_t ib;
    logic       cmd_flag;
    byte_t      cfg;
    byte_evt_t  reply, kbd_tx, aux_tx;
    logic       obf;
    byte_t      obuf;
    byte_t      status;

    kbc_in_latch u_in (
        .clk      (clk),
        .rst      (rst),
        .wr       (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .ib       (ib),
        .cmd_flag (cmd_flag)
    );

    kbc_cmd_seq #(.CODE_W(CODE_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ib       (ib),
        .kbd_code (kbd_line_code),
        .aux_code (aux_line_code),
        .cfg      (cfg),
        .reply    (reply),
        .kbd_tx   (kbd_tx),
        .aux_tx   (aux_tx)
    );

    kbc_out_buf u_out (
        .clk      (clk),
        .rst      (rst),
        .reply    (reply),
        .rx_valid (dev_rx_valid),
        .rx_data  (dev_rx_byte),
        .ibf      (ib.valid),
        .rd_clear (host_rd && !host_addr),
        .obf      (obf),
        .obuf     (obuf),
        .rx_ready (dev_rx_ready)
    );

    assign status       = pack_status(obf, ib.valid, cfg[CFG_SYS], cmd_flag,
                                      kbd_switch_on, dev_err);
    assign host_rdata   = host_addr ? status : obuf;
    assign irq          = obf && cfg[CFG_IRQ_EN];
    assign kbd_tx_valid = kbd_tx.valid;
    assign aux_tx_valid = aux_tx.valid;
    assign tx_byte      = kbd_tx.valid ? kbd_tx.data : aux_tx.data;
    assign cfg_byte     = cfg;

endmodule

// File: tb/kbc_host_if_tb_top.sv
module kbc_host_if_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;
    logic       kbd_switch_on = 1'b1;
    logic [2:0] dev_err = '0;
    logic [2:0] kbd_line_code = '0, aux_line_code = '0;
    logic       dev_rx_valid = 1'b0;
    logic [7:0] dev_rx_byte = '0;
    logic       dev_rx_ready, kbd_tx_valid, aux_tx_valid;
    logic [7:0] tx_byte, cfg_byte;

    int checks = 0, fails = 0;
    int kbd_cnt = 0, aux_cnt = 0;
    logic [7:0] kbd_last = '0, aux_last = '0;

    always #4 clk = ~clk;

    kbc_host_if dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .kbd_switch_on(kbd_switch_on), .dev_err(dev_err),
        .kbd_line_code(kbd_line_code), .aux_line_code(aux_line_code),
        .dev_rx_valid(dev_rx_valid), .dev_rx_byte(dev_rx_byte),
        .dev_rx_ready(dev_rx_ready), .kbd_tx_valid(kbd_tx_valid),
        .aux_tx_valid(aux_tx_valid), .tx_byte(tx_byte), .cfg_byte(cfg_byte)
    );

    always @(negedge clk) begin
        if (kbd_tx_valid) begin kbd_cnt++; kbd_last = tx_byte; end
        if (aux_tx_valid) begin aux_cnt++; aux_last = tx_byte; end
    end

    function automatic logic [7:0] exp_status(input logic obf, input logic [7:0] cfg,
                                              input logic cmd);
        return {3'b000, 1'b1, cmd, cfg[2], 1'b0, obf};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1'b1; #1; d = host_rdata;
        @(negedge clk); host_rd = 1'b0; #1;
    endtask

    task automatic dev_push(input logic [7:0] d, output logic rdy);
        @(negedge clk); #1; rdy = dev_rx_ready; dev_rx_valid = 1'b1; dev_rx_byte = d;
        @(negedge clk); dev_rx_valid = 1'b0; #1;
    endtask

    task automatic cmd_read(input logic [7:0] op, output logic [7:0] d);
        wr(1'b1, op);
        rd(1'b0, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] v, d, s;
        logic r;
        int kc;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        rd(1'b1, s); check("R1 reset status", s, 8'h10);
        check("R10 reset irq", {7'd0, irq}, 8'h00);
        dev_err = 3'b101; rd(1'b1, s); check("R1 error bits", s, 8'hB0); dev_err = '0;

        wr(1'b1, 8'h20); rd(1'b1, s); check("R2 cmd flag + R9 obf", s, 8'h19);
        rd(1'b0, d); check("R4 reset cfg readback", d, 8'h00);
        rd(1'b1, s); check("R9 read clears obf", s, 8'h18);

        kc = kbd_cnt; wr(1'b0, 8'h5A);
        check("R3 forward count", 8'(kbd_cnt - kc), 8'd1);
        check("R3 forward byte", kbd_last, 8'h5A);
        rd(1'b1, s); check("R2 data clears flag", s, 8'h10);

        for (int i = 0; i < 20; i++) begin
            v = 8'($urandom);
            wr(1'b1, 8'h60); wr(1'b0, v); wr(1'b1, 8'h20);
            rd(1'b1, s); check("R1 status sys flag", s, exp_status(1'b1, v, 1'b1));
            check("R10 irq gating", {7'd0, irq}, {7'd0, v[0]});
            rd(1'b0, d); check("R4 cfg write/read", d, v & 8'h7F);
            check("R10 irq after read", {7'd0, irq}, 8'h00);
        end

        wr(1'b1, 8'h60); wr(1'b0, 8'h00);
        wr(1'b1, 8'hAD); cmd_read(8'h20, d); check("R5 kbd off", d, 8'h10);
        wr(1'b1, 8'hAE); cmd_read(8'h20, d); check("R5 kbd on", d, 8'h00);
        wr(1'b1, 8'hA7); cmd_read(8'h20, d); check("R5 aux off", d, 8'h20);
        wr(1'b1, 8'hA8); cmd_read(8'h20, d); check("R5 aux on", d, 8'h00);

        cmd_read(8'hAA, d); check("R6 self test", d, 8'h55);
        kbd_line_code = 3'd3; cmd_read(8'hAB, d); check("R6 kbd line", d, 8'h03);
        aux_line_code = 3'd4; cmd_read(8'hA9, d); check("R6 aux line", d, 8'h04);
        kbd_line_code = 3'd0; cmd_read(8'hAB, d); check("R6 no fault", d, 8'h00);

        for (int i = 0; i < 8; i++) begin
            v = 8'($urandom); kc = kbd_cnt;
            wr(1'b1, 8'hD2); wr(1'b0, v);
            check("R7 D2 not forwarded", 8'(kbd_cnt - kc), 8'd0);
            rd(1'b0, d); check("R7 D2 loads obuf", d, v);
        end
        kc = aux_cnt; wr(1'b1, 8'hD4); wr(1'b0, 8'hC3);
        check("R7 aux count", 8'(aux_cnt - kc), 8'd1);
        check("R7 aux byte", aux_last, 8'hC3);

        cmd_read(8'hA4, d); check("R8 no password", d, 8'hF1);
        wr(1'b1, 8'hA5); wr(1'b0, 8'h00);
        cmd_read(8'hA4, d); check("R8 empty password", d, 8'hF1);
        kc = kbd_cnt; wr(1'b1, 8'hA5); wr(1'b0, 8'h31); wr(1'b0, 8'h32);
        check("R8 password absorbed", 8'(kbd_cnt - kc), 8'd0);
        wr(1'b0, 8'h00);
        cmd_read(8'hA4, d); check("R8 password installed", d, 8'hFA);

        wr(1'b1, 8'h60); wr(1'b1, 8'hB5);
        rd(1'b1, s); check("R12 unknown no reply", s, 8'h18);
        wr(1'b0, 8'h41); cmd_read(8'h20, d); check("R12 pending kept", d, 8'h41);
        wr(1'b1, 8'h60); cmd_read(8'hAA, d);
        kc = kbd_cnt; wr(1'b0, 8'h77);
        check("R12 known cancels pending", kbd_last, 8'h77);
        check("R12 forwarded once", 8'(kbd_cnt - kc), 8'd1);
        cmd_read(8'h20, d); check("R12 cfg unchanged", d, 8'h41);

        dev_push(8'h9C, r); check("R11 ready when empty", {7'd0, r}, 8'h01);
        rd(1'b0, d); check("R11 device byte", d, 8'h9C);
        dev_push(8'h11, r); dev_push(8'h22, r);
        check("R11 not ready when full", {7'd0, r}, 8'h00);
        rd(1'b0, d); check("R11 full ignores", d, 8'h11);
        dev_push(8'h33, r); cmd_read(8'hAA, d); check("R9 reply overwrites", d, 8'h55);

        kc = kbd_cnt;
        @(negedge clk); host_wr = 1'b1; host_addr = 1'b0; host_wdata = 8'h11;
        @(negedge clk); host_wdata = 8'h22;
        @(negedge clk); host_wr = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        check("R2 busy write dropped", 8'(kbd_cnt - kc), 8'd1);
        check("R2 first write kept", kbd_last, 8'h11);

        for (int i = 0; i < 16; i++) begin
            v = 8'($urandom); wr(1'b0, v);
            check("R3 random forward", kbd_last, v);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule